// File: doc/BRIEF.md
# Binary Synchronous Block Check Engine

This block works out the block check for byte-oriented binary synchronous frames and, on the receive side, decides whether a frame arrived intact. Bytes enter on a valid/ready stream. Each byte carries a start-of-frame qualifier and a check-byte qualifier. A static mode pin selects one of two checks: a zero-preset CRC-16, or a longitudinal check that takes even parity down each bit column of the frame. The frame terminator (ETX, ETB or ITB) is sent as an ordinary data byte and falls inside the check. The check characters come after it and are marked as check bytes.

In transparent receive, the block removes escape characters (DLE, 0x10) from the data stream and leaves them out of the check. A DLE-SYN idle pair is removed completely. In transmit the host has already placed every escape in the stream, so each data byte is forwarded and accumulated as supplied. Forwarded bytes leave on a one-stage valid/ready output. The output register can accept a new byte when it is empty or is being drained in the same cycle, so `s_ready = !m_valid || m_ready`. A byte offered while the output is full and stalled waits on the input until room appears. A held output byte stays stable until it is taken. Bytes that are dropped, and check bytes, still pass through this handshake but never reach the output.

Top module: `bsc_engine`

## Requirements
- R1: After synchronous active-high reset, `chk_value` is 0, `m_valid` is 0, `frame_done` is 0 and `s_ready` is 1.
- R2: With `cfg_lrc`=0, every accumulated byte updates `chk_value` by the reflected CRC-16 for x^16+x^15+x^2+1 (constant 0xA001). The byte is XORed into the low bits and then shifted right eight times, LSB first. The new value is visible the cycle after the byte is accepted.
- R3: With `cfg_lrc`=1, `chk_value[7:0]` is the XOR of all accumulated bytes and `chk_value[15:8]` is 0. For example, 0x91, 0xC1, 0xC1 give 0x0091.
- R4: A byte accepted with `s_sof`=1 is processed from a zeroed check register, a zero check-byte count and no pending escape.
- R5: Bytes with `s_bcc`=1 are accumulated like data. When the second check byte (CRC mode, sent low byte first) or the first check byte (LRC mode) is accepted, `frame_done` pulses for one cycle on the next cycle. In that cycle `frame_ok` is 1 exactly when the register has become zero, that is, when the received check matches.
- R6: With `cfg_rx`=1 and `cfg_transparent`=1, a DLE data byte that has no escape pending is neither accumulated nor forwarded, and it makes an escape pending.
- R7: In that mode, with an escape pending, a SYN (0x16) is dropped and not accumulated. Any other byte, including a second DLE, is forwarded and accumulated. Either way the pending escape clears.
- R8: With `cfg_rx`=0 or `cfg_transparent`=0, every data byte, DLE and SYN included, is forwarded and accumulated.
- R9: Check bytes are never forwarded.
- R10: `s_ready = !m_valid || m_ready`, and while `m_valid` is high and `m_ready` is low, `m_data` and `m_valid` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lrc | input | 1 | 0: CRC-16, 1: longitudinal parity |
| cfg_rx | input | 1 | 1: receive direction, 0: transmit |
| cfg_transparent | input | 1 | Transparent framing (escape handling on receive) |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted when high with s_valid |
| s_data | input | 8 | Input byte |
| s_sof | input | 1 | Byte is the first of a frame |
| s_bcc | input | 1 | Byte is a check character |
| m_valid | output | 1 | Forwarded byte valid |
| m_ready | input | 1 | Downstream takes the forwarded byte |
| m_data | output | 8 | Forwarded byte |
| chk_value | output | 16 | Running check register |
| frame_done | output | 1 | One-cycle pulse after the final check byte |
| frame_ok | output | 1 | Check matched; valid with frame_done |

## Verification
`chk_value`, `m_valid`/`m_data` and `frame_done`/`frame_ok` are all registered at the edge that accepts a byte, so each result is due one cycle after acceptance. The bench drives inputs on falling edges and returns from its send routine at the falling edge that follows the accepting edge. It reads `chk_value` at that point. Forwarded bytes and frame-end pulses are captured by a rising-edge monitor, so the bench waits one more falling edge before it compares them. The stall test holds `m_ready` low and reads `s_ready` and `m_data` on several falling edges before releasing it.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic {CHK_CRC = 1'b0, CHK_LRC = 1'b1} chk_mode_e;

  localparam logic [7:0] CODE_DLE = 8'h10;
  localparam logic [7:0] CODE_SYN = 8'h16;
  localparam logic [15:0] CRC_REFLECTED_POLY = 16'hA001;

  // number of check characters that close a frame in each mode
  function automatic logic [1:0] bcc_len(input chk_mode_e m);
    return (m == CHK_LRC) ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/bsc_escape_filter.sv
module bsc_escape_filter #(
  parameter int DW = 8,
  parameter logic [DW-1:0] ESC = 8'h10,
  parameter logic [DW-1:0] IDLE = 8'h16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic          sof,
  input  logic          is_bcc,
  input  logic          strip_en,
  input  logic [DW-1:0] data,
  output logic          take,
  output logic          pass
);
  logic pending;
  logic pend_eff;
  logic set_pend;

  assign pend_eff = sof ? 1'b0 : pending;

  always_comb begin
    take = 1'b1;
    pass = 1'b1;
    set_pend = 1'b0;
    if (is_bcc) begin
      pass = 1'b0;
    end else if (strip_en) begin
      if (pend_eff) begin
        if (data == IDLE) begin
          take = 1'b0;
          pass = 1'b0;
        end
      end else if (data == ESC) begin
        take = 1'b0;
        pass = 1'b0;
        set_pend = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b0;
    else if (fire) pending <= set_pend;
  end

  // R7: any byte taken while an escape is pending settles it
  a_r7_pending_clears: assert property (@(posedge clk) disable iff (rst)
    (pending && fire && !sof) |=> !pending);
endmodule

// File: rtl/bsc_check_accum.sv
module bsc_check_accum #(
  parameter int DW = 8,
  parameter int CW = 16,
  parameter logic [CW-1:0] POLY = 16'hA001
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic          sof,
  input  logic          take,
  input  logic          mode_lrc,
  input  logic [DW-1:0] data,
  output logic [CW-1:0] chk,
  output logic          next_zero
);
  localparam int PADW = CW - DW;

  logic [CW-1:0] base;
  logic [CW-1:0] nxt;
  logic [CW-1:0] stg [0:DW];
  logic [DW-1:0] col;

  assign base = sof ? '0 : chk;
  assign stg[0] = base ^ {{PADW{1'b0}}, data};

  for (genvar g = 0; g < DW; g++) begin : g_crc_bit
    assign stg[g+1] = stg[g][0] ? ((stg[g] >> 1) ^ POLY) : (stg[g] >> 1);
  end

  for (genvar b = 0; b < DW; b++) begin : g_lrc_col
    assign col[b] = base[b] ^ data[b];
  end

  always_comb begin
    if (!take) nxt = base;
    else if (mode_lrc) nxt = {{PADW{1'b0}}, col};
    else nxt = stg[DW];
  end

  assign next_zero = (nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) chk <= '0;
    else if (fire) chk <= nxt;
  end

  // R3: the parity mode never sets the upper half
  a_r3_lrc_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (fire && mode_lrc) |=> (chk[CW-1:DW] == '0));
endmodule

// File: rtl/bsc_frame_judge.sv
module bsc_frame_judge
  import bsc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic sof,
  input  logic is_bcc,
  input  logic mode_lrc,
  input  logic next_zero,
  output logic done,
  output logic ok
);
  logic [1:0] cnt;
  logic [1:0] cnt_base;
  logic [1:0] need;

  assign cnt_base = sof ? 2'd0 : cnt;
  assign need = bcc_len(mode_lrc ? CHK_LRC : CHK_CRC);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= 2'd0;
      done <= 1'b0;
      ok   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (fire && is_bcc) begin
        if (cnt_base + 2'd1 >= need) begin
          cnt  <= 2'd0;
          done <= 1'b1;
          ok   <= next_zero;
        end else begin
          cnt <= cnt_base + 2'd1;
        end
      end else if (fire && sof) begin
        cnt <= 2'd0;
      end
    end
  end

  // R5: frame end is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/bsc_engine.sv
module bsc_engine
  import bsc_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 16,
  parameter logic [CW-1:0] POLY = CRC_REFLECTED_POLY,
  parameter logic [DW-1:0] ESC = CODE_DLE,
  parameter logic [DW-1:0] IDLE = CODE_SYN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_lrc,
  input  logic          cfg_rx,
  input  logic          cfg_transparent,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic          s_sof,
  input  logic          s_bcc,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  output logic [CW-1:0] chk_value,
  output logic          frame_done,
  output logic          frame_ok
);
  logic fire;
  logic take;
  logic pass;
  logic strip_en;
  logic next_zero;

  assign s_ready  = !m_valid || m_ready;
  assign fire     = s_valid && s_ready;
  assign strip_en = cfg_rx && cfg_transparent;

  bsc_escape_filter #(.DW(DW), .ESC(ESC), .IDLE(IDLE)) u_filter (
    .clk(clk), .rst(rst), .fire(fire), .sof(s_sof), .is_bcc(s_bcc),
    .strip_en(strip_en), .data(s_data), .take(take), .pass(pass)
  );

  bsc_check_accum #(.DW(DW), .CW(CW), .POLY(POLY)) u_accum (
    .clk(clk), .rst(rst), .fire(fire), .sof(s_sof), .take(take),
    .mode_lrc(cfg_lrc), .data(s_data), .chk(chk_value), .next_zero(next_zero)
  );

  bsc_frame_judge u_judge (
    .clk(clk), .rst(rst), .fire(fire), .sof(s_sof), .is_bcc(s_bcc),
    .mode_lrc(cfg_lrc), .next_zero(next_zero), .done(frame_done), .ok(frame_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (fire && pass) begin
      m_valid <= 1'b1;
      m_data  <= s_data;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  // R10: a stalled output byte is held
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  // R9: a check byte never produces output
  a_r9_bcc_not_forwarded: assert property (@(posedge clk) disable iff (rst)
    (fire && s_bcc) |=> !m_valid);
  // R6: an escape opening a frame in transparent receive is swallowed
  a_r6_dle_dropped: assert property (@(posedge clk) disable iff (rst)
    (fire && cfg_rx && cfg_transparent && s_sof && !s_bcc && s_data == ESC) |=> !m_valid);
endmodule

// File: tb/tb_bsc_engine.sv
`timescale 1ns/1ps
module tb_bsc_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_lrc = 1'b0, cfg_rx = 1'b1, cfg_transparent = 1'b0;
  logic s_valid = 1'b0, s_sof = 1'b0, s_bcc = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic s_ready, m_valid, frame_done, frame_ok;
  logic m_ready = 1'b1;
  logic [7:0] m_data;
  logic [15:0] chk_value;

  int checks = 0, failures = 0;
  int done_cnt = 0;
  bit last_ok = 1'b0;
  bit finished = 1'b0;
  logic [7:0] outq[$];

  always #5 clk = ~clk;

  bsc_engine dut (
    .clk(clk), .rst(rst), .cfg_lrc(cfg_lrc), .cfg_rx(cfg_rx),
    .cfg_transparent(cfg_transparent), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sof(s_sof), .s_bcc(s_bcc), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .chk_value(chk_value),
    .frame_done(frame_done), .frame_ok(frame_ok)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (m_valid && m_ready) outq.push_back(m_data);
      if (frame_done) begin
        done_cnt++;
        last_ok = frame_ok;
      end
    end
  end

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ d[i];
      r = (r >> 1) ^ (fb ? 16'hA001 : 16'h0000);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input bit sof, input bit bcc);
    s_data = d; s_sof = sof; s_bcc = bcc; s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_bcc = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] c;
    logic [7:0] seq [7];
    logic [7:0] exp_out [4];
    int dc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 chk_value", chk_value, 0);
    chk("R1 m_valid", m_valid, 0);
    chk("R1 frame_done", frame_done, 0);
    chk("R1 s_ready", s_ready, 1);

    // R2 and R4: every single-byte frame restarts from zero
    for (int v = 0; v < 256; v++) begin
      send(8'(v), 1'b1, 1'b0);
      chk("R2/R4 crc single byte", chk_value, ref_crc(16'h0, 8'(v)));
    end
    settle();
    outq.delete();

    // R5: good CRC frame, then a corrupted one
    for (int k = 0; k < 2; k++) begin
      c = 16'h0;
      for (int i = 0; i < 6; i++) begin
        logic [7:0] b = (i == 5) ? 8'h03 : 8'(8'h41 + i * 7);
        send(b, i == 0, 1'b0);
        c = ref_crc(c, b);
      end
      chk("R2 crc frame", chk_value, c);
      dc = done_cnt;
      send(c[7:0] ^ 8'(k), 1'b0, 1'b1);
      send(c[15:8], 1'b0, 1'b1);
      @(negedge clk);
      chk("R5 done pulse", done_cnt, dc + 1);
      chk(k == 0 ? "R5 crc good" : "R5 crc bad", last_ok, k == 0);
    end
    settle();
    chk("R9 crc frame output count", outq.size(), 12);
    outq.delete();

    // R3: worked parity example, then parity check good and bad
    cfg_lrc = 1'b1;
    for (int k = 0; k < 2; k++) begin
      send(8'h91, 1'b1, 1'b0);
      send(8'hC1, 1'b0, 1'b0);
      send(8'hC1, 1'b0, 1'b0);
      chk("R3 lrc example", chk_value, 16'h0091);
      dc = done_cnt;
      send(k == 0 ? 8'h91 : 8'h90, 1'b0, 1'b1);
      @(negedge clk);
      chk("R5 lrc done", done_cnt, dc + 1);
      chk(k == 0 ? "R5 lrc good" : "R5 lrc bad", last_ok, k == 0);
    end
    // R3: sweep of two-byte parity frames
    for (int v = 0; v < 256; v++) begin
      send(8'(v), 1'b1, 1'b0);
      send(8'(v) ^ 8'h5A, 1'b0, 1'b0);
      chk("R3 lrc sweep", chk_value, 16'h005A);
    end
    settle();
    outq.delete();
    cfg_lrc = 1'b0;

    // R6/R7: transparent receive stream A DLE DLE DLE SYN B ETX
    cfg_transparent = 1'b1;
    seq = '{8'h41, 8'h10, 8'h10, 8'h10, 8'h16, 8'h42, 8'h03};
    exp_out = '{8'h41, 8'h10, 8'h42, 8'h03};
    for (int i = 0; i < 7; i++) send(seq[i], i == 0, 1'b0);
    c = 16'h0;
    for (int i = 0; i < 4; i++) c = ref_crc(c, exp_out[i]);
    chk("R6/R7 crc skips escapes", chk_value, c);
    dc = done_cnt;
    send(c[7:0], 1'b0, 1'b1);
    send(c[15:8], 1'b0, 1'b1);
    settle();
    chk("R5 transparent good", last_ok, 1);
    chk("R6/R7/R9 output count", outq.size(), 4);
    for (int i = 0; i < 4 && i < outq.size(); i++)
      chk("R6/R7 output byte", outq[i], exp_out[i]);
    outq.delete();

    // R4: start-of-frame discards a pending escape
    send(8'h10, 1'b1, 1'b0);
    send(8'h16, 1'b1, 1'b0);
    chk("R4 sof clears escape", chk_value, ref_crc(16'h0, 8'h16));
    settle();
    chk("R4 sof output count", outq.size(), 1);
    if (outq.size() > 0) chk("R4 sof output byte", outq[0], 8'h16);
    outq.delete();

    // R8: transmit forwards and accumulates everything
    cfg_rx = 1'b0;
    c = 16'h0;
    for (int i = 0; i < 7; i++) begin
      send(seq[i], i == 0, 1'b0);
      c = ref_crc(c, seq[i]);
    end
    chk("R8 tx crc all bytes", chk_value, c);
    settle();
    chk("R8 tx output count", outq.size(), 7);
    for (int i = 0; i < 7 && i < outq.size(); i++)
      chk("R8 tx output byte", outq[i], seq[i]);
    outq.delete();
    cfg_rx = 1'b1;
    cfg_transparent = 1'b0;

    // R10: back-pressure
    m_ready = 1'b0;
    send(8'hA5, 1'b1, 1'b0);
    s_data = 8'h5A; s_valid = 1'b1; s_sof = 1'b0; s_bcc = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R10 ready low when full", s_ready, 0);
      chk("R10 data held", m_data, 8'hA5);
      chk("R10 valid held", m_valid, 1);
      @(negedge clk);
    end
    m_ready = 1'b1;
    #1;
    chk("R10 ready when draining", s_ready, 1);
    @(negedge clk);
    s_valid = 1'b0;
    chk("R10 next byte loaded", m_data, 8'h5A);
    settle();
    chk("R10 order", outq.size(), 2);
    if (outq.size() == 2) begin
      chk("R10 first", outq[0], 8'hA5);
      chk("R10 second", outq[1], 8'h5A);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule